// File: doc/BRIEF.md
# Repeated Character Pattern Detector

This block watches the stream of bytes coming out of a serial receiver and recognises a short burst made of one chosen character repeated an exact number of times, with quiet time on both sides. Bursts of this kind are used as escape sequences that switch a modem-style link into command mode. The pattern character, the repeat count and three cycle-count thresholds come in as inputs: minimum quiet time before the burst, the largest allowed spacing inside it, and minimum quiet time after it.

Each received byte arrives as a one-cycle strobe with its data and the receive-FIFO index it was written to. When a burst is accepted the block raises a one-cycle detection pulse and pushes the FIFO index of the burst's first character into a small position queue. Software reads the oldest position without removing it, pops it when done, and flushes the queue together with the receive buffer.

Top module: `char_burst_detect`

## Requirements
- R1: After reset det_pulse is 0, pos_level is 0, pos_lost is 0 and pos_head reads all ones.
- R2: The spacing of a byte is the number of rising clock edges from the edge that sampled the previous strobe to the edge that samples it. A run of exactly pat_count copies of pat_char whose first spacing is at least pre_idle, whose other spacings are below gap_max, and which is followed by at least max(post_idle,1) strobe-free edges gives det_pulse high for the one cycle after edge max(post_idle,1) counted from the last byte's edge.
- R3: A pattern character whose spacing is below pre_idle does not start a run.
- R4: A pattern character whose spacing is at least gap_max does not extend the run; if its spacing is also at least pre_idle it starts a new run at its own index.
- R5: Any other byte clears the run, and a run longer than pat_count is never accepted.
- R6: A byte strobed on or before edge max(post_idle,1) after the last run byte cancels the detection.
- R7: The queued position equals the rx_idx of the run's first byte.
- R8: The queue is first in first out; pos_head shows the oldest entry and does not change without a pop; pos_pop removes it one edge later; a pop on an empty queue is ignored; when empty pos_head is all ones (-1 as a signed value).
- R9: A detection while the queue holds QDEPTH entries is dropped and sets pos_lost, which stays set; a detection on the same edge as a pop is kept.
- R10: flush empties the queue, clears pos_lost, abandons the run in progress and discards a detection on the same edge.
- R11: With pat_count equal to 0 nothing is ever detected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_vld | input | 1 | One-cycle strobe for a received byte |
| rx_data | input | 8 | Received byte |
| rx_idx | input | IDX_W | FIFO write index of the received byte |
| pat_char | input | 8 | Character that forms the pattern |
| pat_count | input | 8 | Required number of repeats |
| gap_max | input | 24 | Inner spacing must be below this |
| pre_idle | input | 24 | Minimum spacing before the first character |
| post_idle | input | 24 | Minimum quiet edges after the last character |
| flush | input | 1 | Clear queue, lost flag and run |
| pos_pop | input | 1 | Remove the oldest queued position |
| det_pulse | output | 1 | One-cycle detection pulse |
| pos_head | output | IDX_W+1 | Oldest position, all ones when empty |
| pos_level | output | clog2(QDEPTH+1) | Number of queued positions |
| pos_lost | output | 1 | Sticky flag for a dropped position |

## Verification
The detection pulse and the queued position both appear right after edge max(post_idle,1) counted from the last run byte, so the bench samples det_pulse at every falling edge of the post-burst window and expects it high at exactly that one index. Queue level and head are read at the falling edge after the pop or flush edge, one register later. Bursts are built with a byte task that strobes for exactly one edge and an idle task that waits a stated number of edges, so every spacing is known in edges and the expected outcome follows from comparing it with the thresholds.

// File: rtl/cbd_pkg.sv
package cbd_pkg;
    localparam int CHR_W = 8;
    localparam int TMR_W = 24;
    localparam int RUN_W = CHR_W + 1;

    function automatic logic [TMR_W-1:0] tmr_inc(input logic [TMR_W-1:0] v);
        return (&v) ? v : v + TMR_W'(1);
    endfunction
endpackage

// File: rtl/cbd_run_track.sv
module cbd_run_track import cbd_pkg::*; #(
    parameter int IDX_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rx_vld,
    input  logic [CHR_W-1:0] rx_data,
    input  logic [IDX_W-1:0] rx_idx,
    input  logic [CHR_W-1:0] pat_char,
    input  logic [CHR_W-1:0] pat_count,
    input  logic [TMR_W-1:0] gap_max,
    input  logic [TMR_W-1:0] pre_idle,
    input  logic [TMR_W-1:0] post_idle,
    input  logic             flush,
    output logic             hit,
    output logic [IDX_W-1:0] hit_pos,
    output logic             det_pulse
);
    typedef struct packed {
        logic [TMR_W-1:0] idle;
        logic [RUN_W-1:0] run;
        logic [IDX_W-1:0] start;
        logic             det;
    } trk_t;

    trk_t s_d, s_q;

    always_comb begin
        s_d     = s_q;
        s_d.det = 1'b0;
        hit     = 1'b0;
        if (rx_vld) begin
            s_d.idle = TMR_W'(1);
            if (rx_data == pat_char) begin
                if (s_q.run != '0 && s_q.idle < gap_max) begin
                    s_d.run = (&s_q.run) ? s_q.run : s_q.run + RUN_W'(1);
                end else if (s_q.idle >= pre_idle) begin
                    s_d.run   = RUN_W'(1);
                    s_d.start = rx_idx;
                end else begin
                    s_d.run = '0;
                end
            end else begin
                s_d.run = '0;
            end
        end else begin
            s_d.idle = tmr_inc(s_q.idle);
            if (s_q.run != '0 && s_q.run == RUN_W'(pat_count) && s_q.idle >= post_idle) begin
                hit     = 1'b1;
                s_d.det = 1'b1;
                s_d.run = '0;
            end
        end
        if (flush) begin
            hit     = 1'b0;
            s_d.det = 1'b0;
            s_d.run = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign hit_pos   = s_q.start;
    assign det_pulse = s_q.det;
endmodule

// File: rtl/cbd_pos_queue.sv
module cbd_pos_queue #(
    parameter int IDX_W = 7,
    parameter int DEPTH = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       push,
    input  logic [IDX_W-1:0]           push_pos,
    input  logic                       pop,
    input  logic                       flush,
    output logic [IDX_W:0]             head,
    output logic [$clog2(DEPTH+1)-1:0] level,
    output logic                       lost
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int LVL_W = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [DEPTH-1:0][IDX_W-1:0] mem;
        logic [PTR_W-1:0]            rd;
        logic [PTR_W-1:0]            wr;
        logic [LVL_W-1:0]            lvl;
        logic                        lost;
    } q_t;

    q_t q_d, q_q;
    logic do_pop, do_push, room;

    function automatic logic [PTR_W-1:0] ptr_next(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
    endfunction

    always_comb begin
        q_d     = q_q;
        do_pop  = pop && (q_q.lvl != '0);
        room    = (q_q.lvl != LVL_W'(DEPTH)) || do_pop;
        do_push = push && room;
        if (push && !room) q_d.lost = 1'b1;
        if (do_push) begin
            q_d.mem[q_q.wr] = push_pos;
            q_d.wr          = ptr_next(q_q.wr);
        end
        if (do_pop) q_d.rd = ptr_next(q_q.rd);
        q_d.lvl = q_q.lvl + LVL_W'(do_push) - LVL_W'(do_pop);
        if (flush) begin
            q_d.rd   = '0;
            q_d.wr   = '0;
            q_d.lvl  = '0;
            q_d.lost = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q_q <= '0;
        else        q_q <= q_d;
    end

    assign head  = (q_q.lvl == '0) ? '1 : {1'b0, q_q.mem[q_q.rd]};
    assign level = q_q.lvl;
    assign lost  = q_q.lost;
endmodule

// File: rtl/char_burst_detect.sv
module char_burst_detect import cbd_pkg::*; #(
    parameter int IDX_W  = 7,
    parameter int QDEPTH = 4
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        rx_vld,
    input  logic [CHR_W-1:0]            rx_data,
    input  logic [IDX_W-1:0]            rx_idx,
    input  logic [CHR_W-1:0]            pat_char,
    input  logic [CHR_W-1:0]            pat_count,
    input  logic [TMR_W-1:0]            gap_max,
    input  logic [TMR_W-1:0]            pre_idle,
    input  logic [TMR_W-1:0]            post_idle,
    input  logic                        flush,
    input  logic                        pos_pop,
    output logic                        det_pulse,
    output logic [IDX_W:0]              pos_head,
    output logic [$clog2(QDEPTH+1)-1:0] pos_level,
    output logic                        pos_lost
);
    logic             hit;
    logic [IDX_W-1:0] hit_pos;

    cbd_run_track #(.IDX_W(IDX_W)) i_track (
        .clk(clk), .rst_n(rst_n), .rx_vld(rx_vld), .rx_data(rx_data), .rx_idx(rx_idx),
        .pat_char(pat_char), .pat_count(pat_count), .gap_max(gap_max),
        .pre_idle(pre_idle), .post_idle(post_idle), .flush(flush),
        .hit(hit), .hit_pos(hit_pos), .det_pulse(det_pulse)
    );

    cbd_pos_queue #(.IDX_W(IDX_W), .DEPTH(QDEPTH)) i_queue (
        .clk(clk), .rst_n(rst_n), .push(hit), .push_pos(hit_pos), .pop(pos_pop),
        .flush(flush), .head(pos_head), .level(pos_level), .lost(pos_lost)
    );
endmodule

// File: rtl/cbd_checker.sv
module cbd_checker import cbd_pkg::*; #(
    parameter int IDX_W  = 7,
    parameter int QDEPTH = 4
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        rx_vld,
    input logic                        flush,
    input logic                        pos_pop,
    input logic                        det_pulse,
    input logic [IDX_W:0]              pos_head,
    input logic [$clog2(QDEPTH+1)-1:0] pos_level,
    input logic                        pos_lost
);
    // R2, R6: a detection is only registered on an edge without a byte strobe
    p_det_quiet_edge_r6: assert property (@(posedge clk) disable iff (!rst_n)
        det_pulse |-> $past(!rx_vld));

    // R2: the pulse lasts one cycle
    p_det_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        det_pulse |=> !det_pulse);

    // R8: empty queue reads all ones
    p_empty_head_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (pos_level == '0) |-> (&pos_head));

    // R8: a pop of a non-empty queue lowers the level by one unless a push lands
    p_pop_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (pos_pop && pos_level != '0 && !flush) |=>
        (int'(pos_level) == int'($past(pos_level)) - 1 + int'(det_pulse)));

    // R9: level bounded and lost flag sticky until flush
    p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
        int'(pos_level) <= QDEPTH);
    p_lost_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (pos_lost && !flush) |=> pos_lost);

    // R10: flush empties the queue and clears the lost flag
    p_flush_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (pos_level == '0 && !pos_lost));
endmodule

bind char_burst_detect cbd_checker #(.IDX_W(IDX_W), .QDEPTH(QDEPTH)) i_cbd_checker (
    .clk(clk), .rst_n(rst_n), .rx_vld(rx_vld), .flush(flush), .pos_pop(pos_pop),
    .det_pulse(det_pulse), .pos_head(pos_head), .pos_level(pos_level), .pos_lost(pos_lost)
);

// File: tb/test_char_burst_detect.sv
module test_char_burst_detect;
    localparam int IDX_W = 7;
    localparam int QD    = 4;
    localparam int PRE   = 6;
    localparam int GAP   = 4;
    localparam int POST  = 5;
    localparam logic [7:0] PCH  = 8'h2B;
    localparam logic [7:0] FILL = 8'h41;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rx_vld = 1'b0;
    logic [7:0] rx_data = '0;
    logic [IDX_W-1:0] rx_idx = '0;
    logic [7:0] pat_count = 8'd3;
    logic flush = 1'b0;
    logic pos_pop = 1'b0;
    logic det_pulse;
    logic [IDX_W:0] pos_head;
    logic [$clog2(QD+1)-1:0] pos_level;
    logic pos_lost;

    int checks = 0;
    int errors = 0;
    logic [IDX_W-1:0] idx_ctr = '0;

    always #5 clk = ~clk;

    char_burst_detect #(.IDX_W(IDX_W), .QDEPTH(QD)) i_char_burst_detect (
        .clk(clk), .rst_n(rst_n), .rx_vld(rx_vld), .rx_data(rx_data), .rx_idx(rx_idx),
        .pat_char(PCH), .pat_count(pat_count), .gap_max(24'(GAP)),
        .pre_idle(24'(PRE)), .post_idle(24'(POST)), .flush(flush), .pos_pop(pos_pop),
        .det_pulse(det_pulse), .pos_head(pos_head), .pos_level(pos_level), .pos_lost(pos_lost)
    );

    task automatic check_eq(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic send(input logic [7:0] b);
        rx_data = b;
        rx_idx  = idx_ctr;
        rx_vld  = 1'b1;
        @(negedge clk);
        rx_vld  = 1'b0;
        idx_ctr = idx_ctr + 1'b1;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pop_one();
        pos_pop = 1'b1;
        @(negedge clk);
        pos_pop = 1'b0;
    endtask

    task automatic burst(input int pre, input int mid, input int n, input int post,
                         input bit pop_at_det, output logic [IDX_W-1:0] first, output bit exp);
        string tag;
        first = '0;
        exp = (pat_count != 0) && (pre >= PRE) && (n == 1 || mid < GAP) &&
              (n == int'(pat_count)) && (post > POST);
        if (pat_count == 0)           tag = "R11";
        else if (pre < PRE)           tag = "R3";
        else if (n > 1 && mid >= GAP) tag = "R4";
        else if (n != int'(pat_count)) tag = "R5";
        else if (post <= POST)        tag = "R6";
        else                          tag = "R2";
        idle(20);
        send(FILL);
        idle(pre - 1);
        for (int i = 0; i < n; i++) begin
            if (i > 0) idle(mid - 1);
            if (i == 0) first = idx_ctr;
            send(PCH);
        end
        for (int k = 1; k < post; k++) begin
            if (pop_at_det && k == POST) pos_pop = 1'b1;
            @(negedge clk);
            pos_pop = 1'b0;
            check_eq({tag, " det_pulse in window"}, int'(det_pulse), int'(exp && k == POST));
        end
        send(FILL);
    endtask

    initial begin
        logic [IDX_W-1:0] f;
        logic [IDX_W-1:0] fq [6];
        bit e;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        check_eq("R1 det_pulse", int'(det_pulse), 0);
        check_eq("R1 level", int'(pos_level), 0);
        check_eq("R1 lost", int'(pos_lost), 0);
        check_eq("R1 head", int'($signed(pos_head)), -1);

        // R2..R7 sweep over spacings and run length
        for (int a = 0; a < 2; a++)
            for (int b = 0; b < 2; b++)
                for (int c = 0; c < 3; c++)
                    for (int d = 0; d < 2; d++) begin
                        burst(PRE - 1 + a, GAP - 1 + b, 2 + c, POST + d, 1'b0, f, e);
                        check_eq("R2 level after burst", int'(pos_level), int'(e));
                        if (e) begin
                            check_eq("R7 position", int'(pos_head), int'(f));
                            pop_one();
                            check_eq("R8 level after pop", int'(pos_level), 0);
                        end
                    end

        // R4 restart: long spacing that also meets pre-idle begins a new run
        idle(20); send(FILL); idle(9); send(PCH); idle(7);
        f = idx_ctr; send(PCH); idle(1); send(PCH); idle(1); send(PCH);
        idle(12);
        check_eq("R4 restart level", int'(pos_level), 1);
        check_eq("R4 restart position", int'(pos_head), int'(f));
        pop_one();

        // R5 non-pattern byte inside the run
        idle(20); send(FILL); idle(9); send(PCH); idle(1); send(PCH); idle(1);
        send(FILL); idle(1); send(PCH); idle(12);
        check_eq("R5 cleared run", int'(pos_level), 0);

        // R11 zero repeat count, then count 1 works
        pat_count = 8'd0;
        burst(8, 2, 1, 10, 1'b0, f, e);
        check_eq("R11 no detection", int'(pos_level), 0);
        pat_count = 8'd1;
        burst(8, 2, 1, 10, 1'b0, f, e);
        check_eq("R2 single char level", int'(pos_level), 1);
        pop_one();
        pat_count = 8'd3;

        // R8/R9 queue fill, overflow, pop alongside push
        for (int i = 0; i < 5; i++) begin
            burst(8, 2, 3, 10, 1'b0, fq[i], e);
            check_eq("R9 level while filling", int'(pos_level), (i < QD) ? i + 1 : QD);
        end
        check_eq("R9 lost after overflow", int'(pos_lost), 1);
        check_eq("R8 head peek", int'(pos_head), int'(fq[0]));
        idle(3);
        check_eq("R8 head stable", int'(pos_head), int'(fq[0]));
        burst(8, 2, 3, 10, 1'b1, fq[5], e);
        check_eq("R9 pop with push level", int'(pos_level), QD);
        check_eq("R9 pop with push head", int'(pos_head), int'(fq[1]));
        for (int i = 0; i < QD; i++) begin
            check_eq("R8 fifo order", int'(pos_head), int'(fq[(i < 3) ? i + 1 : 5]));
            pop_one();
        end
        check_eq("R8 empty head", int'($signed(pos_head)), -1);
        pop_one();
        check_eq("R8 pop on empty", int'(pos_level), 0);
        check_eq("R9 lost sticky", int'(pos_lost), 1);

        // R10 flush
        burst(8, 2, 3, 10, 1'b0, f, e);
        flush = 1'b1; @(negedge clk); flush = 1'b0;
        check_eq("R10 flush level", int'(pos_level), 0);
        check_eq("R10 flush lost", int'(pos_lost), 0);
        idle(20); send(FILL); idle(9); send(PCH); idle(1); send(PCH); idle(1); send(PCH);
        flush = 1'b1; @(negedge clk); flush = 1'b0;
        idle(15);
        check_eq("R10 run abandoned", int'(pos_level), 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule